// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the slave end of an external bus that carries the address and the data on the same wires, one after the other. A bus master opens an access by holding chip-select low and giving a one-clock low pulse on bus-start. In that clock the shared bus carries the target address in its low bits and an access-size code in its top three bits. The target keeps both for the rest of the access, because the bus then carries only data. It turns the access into a simple internal memory port with an address, a decoded size, a write strobe and a read strobe.

After the address phase come one or more data beats. The target makes each beat last a fixed number of wait cycles and then raises ready. On a write beat it takes the data from the bus. On a read beat it drives the memory read data onto the bus. The first beat uses the captured address. Each later beat moves the address on by the bus width in bytes and wraps inside the aligned 32-byte block. The master ends the access by raising the frame strobe at the start of the final beat. Chip-select may stay low between accesses, so a new address phase can follow the last ready with no idle clock.

Top module: `mpx_target`

## Requirements
- R1: While reset is held and immediately after it, bus_ready, bus_d_oe, mem_wr and mem_rd are all low.
- R2: A clock with bus_cs_n low and bus_start_n low while no access is open is an address phase. The address is bus_d_in[ADDR_W-1:0], and mem_addr shows it during the whole first data beat.
- R3: The size code is bus_d_in[DATA_W-1:DATA_W-3]. The codes 000, 001 and 010 give mem_size 0 (byte), 1 (word) and 2 (longword). Any code 1xx gives mem_size 3 (32-byte burst). mem_size holds its value for the whole access.
- R4: Each data beat lasts WAIT_CYC+1 clocks. bus_ready is high only in the final clock of a beat.
- R5: If bus_frame_n is high in the first clock of a beat, that beat is the last one. After its ready clock the target is idle: bus_ready and bus_d_oe stay low until the next address phase.
- R6: Every beat after the first has an address DATA_W/8 bytes above the previous one, modulo 32. Address bits from 5 upward never change within an access, so the address wraps within the aligned 32-byte block.
- R7: On write accesses (bus_write high in the address phase), mem_wr pulses only in the ready clock of each beat, with mem_wdata equal to bus_d_in and mem_addr equal to the beat address.
- R8: On read accesses, bus_d_oe is high in every clock of every data beat and bus_d_out equals mem_rdata. mem_rd pulses in the ready clock. bus_d_oe is low during write beats and when idle.
- R9: Size code 011 is unused. Such an access still gives ready for each beat, but it never raises mem_wr or mem_rd, and bus_d_out is zero.
- R10: An address phase placed in the clock right after the final ready clock is accepted. The new access then proceeds normally.
- R11: A bus_start_n pulse is ignored while bus_cs_n is high, and also during data beats. In both cases no ready follows, and the address sequence of an open access is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Chip-select, active low |
| bus_start_n | input | 1 | Bus-start pulse marking the address phase, active low |
| bus_frame_n | input | 1 | Frame strobe; high at the start of a beat marks the final beat |
| bus_write | input | 1 | Access direction, sampled in the address phase (1 = write) |
| bus_d_in | input | DATA_W | Shared bus as seen by the target: address/size, then write data |
| bus_d_out | output | DATA_W | Read data driven toward the bus |
| bus_d_oe | output | 1 | Output enable for bus_d_out |
| bus_ready | output | 1 | Beat-complete indication |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_size | output | 2 | Decoded access size (0 byte, 1 word, 2 longword, 3 burst) |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, combinational from mem_addr |

## Verification
The bench builds the target with DATA_W=32, ADDR_W=26 and WAIT_CYC=1. With a 4-byte step, a 32-byte burst takes eight beats. Starting the burst at offset 0x18 therefore crosses the block boundary and shows the wrap. A single wait cycle selects the counter variant of the beat timer, so every beat has both a not-ready clock and a ready clock to check. The default build (64-bit bus, zero wait) is only elaborated.

// File: rtl/mpx_tgt_pkg.sv
package mpx_tgt_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_LONG  = 2'd2,
      SZ_BURST = 2'd3
   } size_code_e;

   typedef struct packed {
      logic       valid;
      size_code_e code;
   } acc_size_t;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_BEAT = 1'b1
   } phase_e;

   localparam int BLOCK_BITS = 5;

   function automatic acc_size_t decode_size(input logic [2:0] field);
      acc_size_t s;
      s.valid = 1'b1;
      s.code  = SZ_BYTE;
      casez (field)
         3'b1??:  s.code = SZ_BURST;
         3'b000:  s.code = SZ_BYTE;
         3'b001:  s.code = SZ_WORD;
         3'b010:  s.code = SZ_LONG;
         default: s.valid = 1'b0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/mpx_phase_ctl.sv
module mpx_phase_ctl
   import mpx_tgt_pkg::*;
#(
   parameter int WAIT_CYC = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic start_n,
   input  logic frame_n,
   output logic addr_take,
   output logic in_beat,
   output logic beat_rdy,
   output logic beat_last
);

   localparam int CW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

   if (WAIT_CYC < 0) begin : g_bad_wait
      $error("WAIT_CYC must not be negative");
   end

   phase_e ph_q;
   logic   wait_done;

   assign in_beat   = (ph_q == PH_BEAT);
   assign addr_take = (ph_q == PH_IDLE) & ~cs_n & ~start_n;
   assign beat_rdy  = in_beat & wait_done;

   if (WAIT_CYC == 0) begin : g_nowait
      assign wait_done = 1'b1;
      assign beat_last = frame_n;
   end else begin : g_wait
      logic [CW-1:0] wcnt_q;
      logic          last_q;
      logic          first;

      assign first     = (wcnt_q == '0);
      assign wait_done = (wcnt_q == CW'(WAIT_CYC));
      assign beat_last = first ? frame_n : last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wcnt_q <= '0;
            last_q <= 1'b0;
         end else begin
            if (in_beat && !wait_done) wcnt_q <= wcnt_q + 1'b1;
            else                       wcnt_q <= '0;
            if (in_beat && first)      last_q <= frame_n;
         end
      end

      a_r4_ready_spaced: assert property (@(posedge clk) disable iff (!rst_n)
         beat_rdy |=> !beat_rdy);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
      end else begin
         case (ph_q)
            PH_IDLE: if (addr_take)             ph_q <= PH_BEAT;
            PH_BEAT: if (beat_rdy && beat_last) ph_q <= PH_IDLE;
            default:                            ph_q <= PH_IDLE;
         endcase
      end
   end

   a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_rdy && beat_last) |=> !in_beat);

   a_r11_no_take_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (in_beat && !(beat_rdy && beat_last)) |=> in_beat || !addr_take);

endmodule

// File: rtl/mpx_addr_gen.sv
module mpx_addr_gen
   import mpx_tgt_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int STEP   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr
);

   localparam logic [BLOCK_BITS-1:0] STEP_V = BLOCK_BITS'(STEP);

   if (ADDR_W <= BLOCK_BITS) begin : g_bad_aw
      $error("ADDR_W must exceed the block offset width");
   end
   if (STEP < 1 || STEP > (1 << BLOCK_BITS) || (STEP & (STEP - 1)) != 0) begin : g_bad_step
      $error("STEP must be a power of two no larger than the block");
   end

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (take) begin
         addr_q <= d_addr;
      end else if (advance) begin
         addr_q <= {addr_q[ADDR_W-1:BLOCK_BITS], addr_q[BLOCK_BITS-1:0] + STEP_V};
      end
   end

   assign addr = addr_q;

   a_r6_block_kept: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> addr[ADDR_W-1:BLOCK_BITS] == $past(addr[ADDR_W-1:BLOCK_BITS]));

   a_r2_addr_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> addr == $past(d_addr));

endmodule

// File: rtl/mpx_data_path.sv
module mpx_data_path #(
   parameter int DATA_W = 64
) (
   input  logic              in_beat,
   input  logic              beat_rdy,
   input  logic              wr_acc,
   input  logic              size_ok,
   input  logic [DATA_W-1:0] bus_d_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] bus_d_out,
   output logic              bus_d_oe,
   output logic              mem_wr,
   output logic              mem_rd,
   output logic [DATA_W-1:0] mem_wdata
);

   logic rd_beat;

   assign rd_beat   = in_beat & ~wr_acc;
   assign bus_d_oe  = rd_beat;
   assign bus_d_out = (rd_beat & size_ok) ? mem_rdata : '0;
   assign mem_rd    = beat_rdy & ~wr_acc & size_ok;
   assign mem_wr    = beat_rdy &  wr_acc & size_ok;
   assign mem_wdata = bus_d_in;

   always_comb begin
      a_r8_oe_excl_wr: assert (!(bus_d_oe && mem_wr));
   end

endmodule

// File: rtl/mpx_target.sv
module mpx_target
   import mpx_tgt_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int ADDR_W   = 26,
   parameter int WAIT_CYC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_start_n,
   input  logic              bus_frame_n,
   input  logic              bus_write,
   input  logic [DATA_W-1:0] bus_d_in,
   output logic [DATA_W-1:0] bus_d_out,
   output logic              bus_d_oe,
   output logic              bus_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic              mem_wr,
   output logic              mem_rd,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int SZ_LSB = DATA_W - 3;
   localparam int STEP   = DATA_W / 8;

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_dw
      $error("DATA_W must be 32 or 64");
   end
   if (ADDR_W > SZ_LSB) begin : g_bad_aw
      $error("address field overlaps the size field");
   end

   logic      take, in_beat, rdy, last, advance;
   acc_size_t size_q;
   logic      wr_q;

   mpx_phase_ctl #(.WAIT_CYC(WAIT_CYC)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (bus_cs_n),
      .start_n   (bus_start_n),
      .frame_n   (bus_frame_n),
      .addr_take (take),
      .in_beat   (in_beat),
      .beat_rdy  (rdy),
      .beat_last (last)
   );

   assign advance = rdy & ~last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_q <= '0;
         wr_q   <= 1'b0;
      end else if (take) begin
         size_q <= decode_size(bus_d_in[DATA_W-1:SZ_LSB]);
         wr_q   <= bus_write;
      end
   end

   mpx_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .d_addr  (bus_d_in[ADDR_W-1:0]),
      .advance (advance),
      .addr    (mem_addr)
   );

   mpx_data_path #(.DATA_W(DATA_W)) u_data (
      .in_beat   (in_beat),
      .beat_rdy  (rdy),
      .wr_acc    (wr_q),
      .size_ok   (size_q.valid),
      .bus_d_in  (bus_d_in),
      .mem_rdata (mem_rdata),
      .bus_d_out (bus_d_out),
      .bus_d_oe  (bus_d_oe),
      .mem_wr    (mem_wr),
      .mem_rd    (mem_rd),
      .mem_wdata (mem_wdata)
   );

   assign bus_ready = rdy;
   assign mem_size  = size_q.code;

   a_r7_wr_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> bus_ready);

   a_r8_rd_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (bus_ready && bus_d_oe));

   a_r9_unused_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && !size_q.valid) |-> (!mem_wr && !mem_rd && bus_d_out == '0));

   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_beat && !bus_ready) |=> $stable(mem_addr));

   a_r3_size_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_beat && !(bus_ready && last)) |=> $stable(mem_size));

endmodule

// File: tb/mpx_target_test.sv
module mpx_target_test;
   localparam int DW = 32;
   localparam int AW = 26;
   localparam int WT = 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cs_n, start_n, frame_n, wr_i;
   logic [DW-1:0] d_in, d_out, wdata, rdata;
   logic          oe, ready, mem_wr, mem_rd;
   logic [AW-1:0] addr;
   logic [1:0]    msize;

   always #5 clk = ~clk;

   mpx_target #(.DATA_W(DW), .ADDR_W(AW), .WAIT_CYC(WT)) uut (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_start_n(start_n),
      .bus_frame_n(frame_n), .bus_write(wr_i), .bus_d_in(d_in),
      .bus_d_out(d_out), .bus_d_oe(oe), .bus_ready(ready),
      .mem_addr(addr), .mem_size(msize), .mem_wr(mem_wr), .mem_rd(mem_rd),
      .mem_wdata(wdata), .mem_rdata(rdata)
   );

   logic [31:0] mem    [64];
   logic [31:0] shadow [64];
   assign rdata = mem[addr[7:2]];
   always @(posedge clk) if (mem_wr) mem[addr[7:2]] <= wdata;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic go_idle_check();
      @(negedge clk); cs_n = 1'b1; start_n = 1'b1; frame_n = 1'b1; d_in = '0;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R5", "ready after final beat", ready, 0);
         chk("R5", "oe after final beat", oe, 0);
         @(negedge clk);
      end
   endtask

   task automatic access(input logic [25:0] a, input logic [2:0] sz, input bit wr,
                         input int n, input bit poke);
      logic [25:0] ea;
      logic [31:0] dat;
      @(negedge clk);
      cs_n = 1'b0; start_n = 1'b0; frame_n = 1'b0; wr_i = wr; d_in = {sz, 3'b000, a};
      #1;
      chk("R10", "ready in address phase", ready, 0);
      for (int i = 0; i < n; i++) begin
         ea  = {a[25:5], 5'(a[4:0] + 5'(i * 4))};
         dat = 32'hC0DE_0000 + 32'(a) + 32'(i);
         for (int c = 0; c <= WT; c++) begin
            @(negedge clk);
            start_n = (poke && i == 1 && c == 0) ? 1'b0 : 1'b1;
            frame_n = (i == n - 1);
            d_in    = (poke && i == 1 && c == 0) ? 32'h5FFF_FFE0 : (wr ? dat : 32'h0);
            #1;
            chk("R4", "ready timing", ready, (c == WT));
            chk("R8", "oe by direction", oe, !wr);
            if (c < WT) chk("R7", "no write before ready", mem_wr, 0);
            if (c == WT) begin
               chk(i == 0 ? "R2" : "R6", "beat address", addr, ea);
               if (sz != 3'b011) begin
                  chk("R3", "size decode", msize, sz[2] ? 2'd3 : sz[1:0]);
                  if (wr) begin
                     chk("R7", "write strobe", mem_wr, 1);
                     chk("R7", "write data", wdata, dat);
                     shadow[ea[7:2]] = dat;
                  end else begin
                     chk("R8", "read strobe", mem_rd, 1);
                     chk("R8", "read data", d_out, shadow[ea[7:2]]);
                  end
               end else begin
                  chk("R9", "unused write strobe", mem_wr, 0);
                  chk("R9", "unused read strobe", mem_rd, 0);
                  chk("R9", "unused read data", d_out, 0);
               end
            end
         end
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cs_n = 1'b1; start_n = 1'b1; frame_n = 1'b1; wr_i = 1'b0; d_in = '0;
      for (int i = 0; i < 64; i++) begin
         mem[i]    = 32'h1111_0000 + 32'(i);
         shadow[i] = 32'h1111_0000 + 32'(i);
      end
      repeat (3) @(negedge clk);
      chk("R1", "ready in reset", ready, 0);
      chk("R1", "oe in reset", oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", ready, 0);
      chk("R1", "write strobe after reset", mem_wr, 0);
      chk("R1", "read strobe after reset", mem_rd, 0);
   endtask

   task automatic t_single_back_to_back();
      access(26'h000_0010, 3'b010, 1'b1, 1, 1'b0);
      access(26'h000_0010, 3'b010, 1'b0, 1, 1'b0);
      access(26'h000_0021, 3'b000, 1'b1, 1, 1'b0);
      access(26'h000_0026, 3'b001, 1'b1, 1, 1'b0);
      access(26'h000_0024, 3'b010, 1'b0, 1, 1'b0);
      go_idle_check();
   endtask

   task automatic t_bursts();
      access(26'h2A5_4018, 3'b100, 1'b1, 8, 1'b1);
      access(26'h2A5_4018, 3'b100, 1'b0, 8, 1'b0);
      access(26'h000_0084, 3'b111, 1'b0, 8, 1'b0);
      go_idle_check();
      access(26'h000_003C, 3'b101, 1'b0, 2, 1'b0);
      go_idle_check();
   endtask

   task automatic t_unused();
      access(26'h000_0030, 3'b011, 1'b1, 1, 1'b0);
      access(26'h000_0030, 3'b011, 1'b0, 1, 1'b0);
      access(26'h000_0030, 3'b010, 1'b0, 1, 1'b0);
      go_idle_check();
   endtask

   task automatic t_ignore_start();
      @(negedge clk);
      cs_n = 1'b1; start_n = 1'b0; frame_n = 1'b0; d_in = 32'h4000_0040;
      @(negedge clk);
      start_n = 1'b1; frame_n = 1'b1; d_in = '0;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk("R11", "ready without chip-select", ready, 0);
         chk("R11", "oe without chip-select", oe, 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single_back_to_back();
      t_bursts();
      t_unused();
      t_ignore_start();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule